// File: doc/BRIEF.md
# VME Single-Cycle Bus Master

This block is a register file that a plain 16-bit I/O host uses to run single data transfers on a VME backplane. The host loads a 32-bit address, a 6-bit address-modifier code with a long-word flag, and up to 32 bits of data. It then touches the data-low register. When the block is on-line, that access starts one sequenced bus cycle. The sequence raises the bus request, waits for the grant, holds the address for a clock, asserts the address strobe, then asserts the data strobe. It stays there until DTACK arrives, BERR arrives, or a local timeout expires. A wait output holds the host for the whole cycle.

The lowest eight address bits form a counter that can step after each cycle by the transfer width. That lets the host sweep a block of slave memory by repeating data-low accesses. A sticky bus-error flag records failed cycles. An off-line bit turns the data registers into plain storage so that register tests can run without the bus. A soft-reset command clears the control state and pulses a system-reset output.

VME strobes, request, grant, DTACK and BERR are active-high at this boundary; inverting drivers sit outside the block.

Top module: `vme_single_master`

## Requirements
- R1: After reset the block is idle. Request, strobes, write, long-word, wait and system-reset outputs are low, the address output is zero, and the read port returns zero.
- R2: Host offsets are 0x0 (data bits 15:0), 0x2 (data bits 31:16), 0x4 (address bits 15:0), 0x6 (address bits 31:16), 0x8 (modifier: bits 5:0 code, bit 6 long-word) and 0xC (control: bit 3 off-line, bit 5 auto-step, bit 7 soft reset, which reads as 0; bit 8 bus-error flag, read-only). A read presents the selected register on the read port from the next clock. Every other offset, 0xA included, reads 0.
- R3: An on-line read or write of offset 0x0 starts a bus cycle. Wait is high in the access clock itself and stays high until the sequencer is idle again. Host accesses made while busy are ignored, except a soft reset.
- R4: The request rises the clock after the access. One clock after the grant is seen, the address phase begins with the request alone. The address strobe follows one clock later, and the data strobe one clock after that. Address and modifier outputs do not change while the address strobe is high.
- R5: DTACK ends the cycle and all strobes and the request drop on the next clock. A read cycle stores the bus data into data bits 15:0, and into bits 31:16 as well when it is a 32-bit cycle.
- R6: The modifier code drives the AM outputs. With the long-word bit set, the cycle is 32-bit, long-word is high while the request is held, and both data lanes strobe.
- R7: Data-strobe lanes: a 16-bit cycle drives 2'b11. A byte access (host byte input high, long-word bit clear) drives 2'b01 when address bit 0 is 0 and 2'b10 when it is 1.
- R8: With auto-step set, each finished cycle adds 1, 2 or 4 (byte, 16-bit, 32-bit) to address bits 7:0, wrapping with no carry into bit 8.
- R9: BERR seen while the bus is owned ends the cycle and sets the bus-error flag. A write to the modifier register clears the flag.
- R10: If neither DTACK nor BERR arrives, the cycle ends after exactly 64 clocks of data strobe and sets the bus-error flag.
- R11: When off-line, data-register accesses load or return the stored data, start no bus cycle, raise no wait, and leave the address unchanged.
- R12: Writing 1 to control bit 7, even during a cycle, aborts the sequencer and clears off-line, auto-step, address bits 7:0 and the bus-error flag. The system-reset output then goes high for exactly one clock. The modifier and address bits 31:8 are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_sel | input | 1 | Host access strobe, one clock per access |
| hst_wr | input | 1 | Access is a write |
| hst_byte | input | 1 | Access is 8-bit |
| hst_off | input | 4 | Register byte offset |
| hst_wdata | input | 16 | Host write data |
| hst_rdata | output | 16 | Host read data |
| hst_wait | output | 1 | Hold the host; a bus cycle is in progress |
| vme_br | output | 1 | Bus request |
| vme_bg | input | 1 | Bus grant |
| vme_as | output | 1 | Address strobe |
| vme_ds | output | 2 | Data strobes, bit 0 for lane 7:0, bit 1 for lane 15:8 |
| vme_write | output | 1 | Write cycle |
| vme_lword | output | 1 | 32-bit cycle |
| vme_am | output | 6 | Address-modifier code |
| vme_addr | output | 32 | Bus address |
| vme_dout | output | 32 | Write data to the bus |
| vme_din | input | 32 | Read data from the bus |
| vme_dtack | input | 1 | Transfer acknowledge |
| vme_berr | input | 1 | Bus error |
| vme_sysreset | output | 1 | System reset pulse |

## Verification
A wrong sequencer state appears at the strobe and request outputs within one clock. It also shows in the wait output, which must track the bus phases exactly, so it is caught on the next compare. A wrong address counter or bus-error flag stays hidden until the next cycle drives the address or the host reads offsets 0x4 or 0xC. The bench therefore reads these registers back after every kind of cycle ending: DTACK, BERR, timeout and abort. A wrong timeout count shows as a data-strobe run that is not 64 clocks long.

// File: rtl/vme_single_master.sv
`timescale 1ns/1ps
module vme_single_master #(
  parameter int TMO_CYCLES = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hst_sel,
  input  logic        hst_wr,
  input  logic        hst_byte,
  input  logic [3:0]  hst_off,
  input  logic [15:0] hst_wdata,
  output logic [15:0] hst_rdata,
  output logic        hst_wait,
  output logic        vme_br,
  input  logic        vme_bg,
  output logic        vme_as,
  output logic [1:0]  vme_ds,
  output logic        vme_write,
  output logic        vme_lword,
  output logic [5:0]  vme_am,
  output logic [31:0] vme_addr,
  output logic [31:0] vme_dout,
  input  logic [31:0] vme_din,
  input  logic        vme_dtack,
  input  logic        vme_berr,
  output logic        vme_sysreset
);
  localparam int TW = $clog2(TMO_CYCLES);

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_ADDR, S_STRB, S_WAIT, S_REL} st_t;

  st_t         st;
  logic [31:0] dat, adr;
  logic [6:0]  am;
  logic        offl, inc, flag, cwr, sysrst;
  logic [1:0]  cw;
  logic [3:0]  roff;
  logic [TW-1:0] cnt;

  wire idle  = (st == S_IDLE);
  wire acc   = hst_sel & idle;
  wire srst  = hst_sel & hst_wr & (hst_off == 4'hC) & hst_wdata[7];
  wire start = acc & (hst_off == 4'h0) & ~offl;
  wire own   = (st == S_ADDR) | (st == S_STRB) | (st == S_WAIT);
  wire tmo   = (cnt == TW'(TMO_CYCLES - 1));
  wire [7:0] step = 8'd1 << cw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; dat <= '0; adr <= '0; am <= '0;
      offl <= 1'b0; inc <= 1'b0; flag <= 1'b0; cwr <= 1'b0;
      cw <= 2'd1; roff <= '0; cnt <= '0; sysrst <= 1'b0;
    end else begin
      sysrst <= srst;
      if (srst) begin
        st <= S_IDLE; offl <= 1'b0; inc <= 1'b0; flag <= 1'b0;
        adr[7:0] <= 8'h00;
      end else begin
        if (own & vme_berr) flag <= 1'b1;
        if (acc & hst_wr) begin
          case (hst_off)
            4'h0: dat[15:0]  <= hst_wdata;
            4'h2: dat[31:16] <= hst_wdata;
            4'h4: adr[15:0]  <= hst_wdata;
            4'h6: adr[31:16] <= hst_wdata;
            4'h8: begin am <= hst_wdata[6:0]; flag <= 1'b0; end
            4'hC: begin offl <= hst_wdata[3]; inc <= hst_wdata[5]; end
            default: ;
          endcase
        end
        if (acc & ~hst_wr) roff <= hst_off;
        case (st)
          S_IDLE: if (start) begin
            st  <= S_REQ;
            cwr <= hst_wr;
            cw  <= am[6] ? 2'd2 : (hst_byte ? 2'd0 : 2'd1);
          end
          S_REQ:  if (vme_bg) st <= S_ADDR;
          S_ADDR: st <= S_STRB;
          S_STRB: begin st <= S_WAIT; cnt <= '0; end
          S_WAIT: begin
            if (vme_dtack) begin
              st <= S_REL;
              if (!cwr) begin
                dat[15:0] <= vme_din[15:0];
                if (cw == 2'd2) dat[31:16] <= vme_din[31:16];
              end
            end else if (vme_berr) begin
              st <= S_REL;
            end else if (tmo) begin
              st <= S_REL; flag <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_REL: begin
            st <= S_IDLE;
            if (inc) adr[7:0] <= adr[7:0] + step;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign vme_br       = (st == S_REQ) | own;
  assign vme_as       = (st == S_STRB) | (st == S_WAIT);
  assign vme_ds       = (st != S_WAIT) ? 2'b00 :
                        (cw == 2'd0) ? (adr[0] ? 2'b10 : 2'b01) : 2'b11;
  assign vme_write    = cwr & vme_br;
  assign vme_lword    = (cw == 2'd2) & vme_br;
  assign vme_am       = am[5:0];
  assign vme_addr     = adr;
  assign vme_dout     = dat;
  assign vme_sysreset = sysrst;
  assign hst_wait     = ~idle | start;

  always_comb begin
    case (roff)
      4'h0:    hst_rdata = dat[15:0];
      4'h2:    hst_rdata = dat[31:16];
      4'h4:    hst_rdata = adr[15:0];
      4'h6:    hst_rdata = adr[31:16];
      4'h8:    hst_rdata = {9'b0, am};
      4'hC:    hst_rdata = {7'b0, flag, 2'b0, inc, 1'b0, offl, 3'b0};
      default: hst_rdata = 16'h0000;
    endcase
  end
endmodule

// File: rtl/vme_single_master_chk.sv
`timescale 1ns/1ps
module vme_single_master_chk #(
  parameter int TMO_CYCLES = 64
) (
  input logic        clk,
  input logic        rst_n,
  input logic        hst_wait,
  input logic        vme_br,
  input logic        vme_as,
  input logic [1:0]  vme_ds,
  input logic        vme_lword,
  input logic [5:0]  vme_am,
  input logic [31:0] vme_addr,
  input logic        vme_sysreset
);
  int ds_run;

  p_as_owns_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vme_as |-> vme_br);

  p_ds_after_as_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vme_ds != 2'b00) |-> $past(vme_as));

  p_addr_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vme_as |-> ($stable(vme_addr) && $stable(vme_am)));

  p_wait_covers_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vme_br |-> hst_wait);

  p_lword_lanes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vme_lword && vme_ds != 2'b00) |-> (vme_ds == 2'b11));

  p_sysreset_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    vme_sysreset |-> !vme_br);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ds_run <= 0;
    else begin
      ds_run <= (vme_ds != 2'b00) ? ds_run + 1 : 0;
      p_tmo_bound_r10: assert (ds_run <= TMO_CYCLES);
    end
  end
endmodule

bind vme_single_master vme_single_master_chk #(.TMO_CYCLES(TMO_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .hst_wait(hst_wait), .vme_br(vme_br),
  .vme_as(vme_as), .vme_ds(vme_ds), .vme_lword(vme_lword), .vme_am(vme_am),
  .vme_addr(vme_addr), .vme_sysreset(vme_sysreset)
);

// File: tb/vme_single_master_tb.sv
`timescale 1ns/1ps
module vme_single_master_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic hst_sel = 0, hst_wr = 0, hst_byte = 0;
  logic [3:0] hst_off = 0;
  logic [15:0] hst_wdata = 0;
  logic [15:0] hst_rdata;
  logic hst_wait, vme_br, vme_as, vme_write, vme_lword, vme_sysreset;
  logic vme_bg = 0, vme_dtack = 0, vme_berr = 0;
  logic [1:0] vme_ds;
  logic [5:0] vme_am;
  logic [31:0] vme_addr, vme_dout;
  logic [31:0] vme_din = 0;

  always #2.5 clk = ~clk;

  vme_single_master u_dut (.*);

  int vectors = 0, miscompares = 0;
  bit done = 0;

  // slave and arbiter stand-ins
  int rmode = 0, rdly = 2, rcnt = 0;
  always @(posedge clk) begin
    #1;
    vme_bg = vme_br;
    if (vme_ds != 2'b00) begin
      rcnt++;
      vme_dtack = (rmode == 0) && (rcnt >= rdly);
      vme_berr  = (rmode == 1) && (rcnt >= rdly);
    end else begin
      rcnt = 0; vme_dtack = 0; vme_berr = 0;
    end
  end

  // behavioural reference
  int m_ph, m_tmo, m_w;
  bit m_wr, m_offl, m_inc, m_flag, m_sysr;
  logic [31:0] m_dat, m_adr;
  logic [6:0] m_am;
  logic [3:0] m_roff;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_tmo = 0; m_w = 2; m_wr = 0; m_offl = 0; m_inc = 0;
      m_flag = 0; m_sysr = 0; m_dat = 0; m_adr = 0; m_am = 0; m_roff = 0;
    end else begin
      bit srst;
      srst = hst_sel && hst_wr && hst_off == 4'hC && hst_wdata[7];
      m_sysr = srst;
      if (srst) begin
        m_ph = 0; m_offl = 0; m_inc = 0; m_flag = 0; m_adr[7:0] = 0;
      end else begin
        if (vme_berr && m_ph >= 2 && m_ph <= 4) m_flag = 1;
        case (m_ph)
          0: if (hst_sel) begin
            if (!hst_wr) m_roff = hst_off;
            else case (hst_off)
              4'h0: m_dat[15:0] = hst_wdata;
              4'h2: m_dat[31:16] = hst_wdata;
              4'h4: m_adr[15:0] = hst_wdata;
              4'h6: m_adr[31:16] = hst_wdata;
              4'h8: begin m_am = hst_wdata[6:0]; m_flag = 0; end
              4'hC: begin m_offl = hst_wdata[3]; m_inc = hst_wdata[5]; end
              default: ;
            endcase
            if (hst_off == 4'h0 && !m_offl) begin
              m_ph = 1; m_wr = hst_wr;
              m_w = m_am[6] ? 4 : (hst_byte ? 1 : 2);
            end
          end
          1: if (vme_bg) m_ph = 2;
          2: m_ph = 3;
          3: begin m_ph = 4; m_tmo = 0; end
          4: if (vme_dtack) begin
               m_ph = 5;
               if (!m_wr) begin
                 m_dat[15:0] = vme_din[15:0];
                 if (m_w == 4) m_dat[31:16] = vme_din[31:16];
               end
             end else if (vme_berr) m_ph = 5;
             else if (m_tmo == 63) begin m_ph = 5; m_flag = 1; end
             else m_tmo++;
          default: begin
            if (m_inc) m_adr[7:0] = m_adr[7:0] + m_w[7:0];
            m_ph = 0;
          end
        endcase
      end
    end
  end

  bit bad;
  task automatic sig(input string tag, input logic [31:0] got, input logic [31:0] exp);
    if (got !== exp) begin
      $display("FAIL %s got %h expected %h at %0t", tag, got, exp, $time);
      bad = 1;
    end
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  int ds_run = 0, last_run = 0, br_cycles = 0;
  logic [1:0] last_ds = 0;
  bit saw_lw = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit e_br;
      logic [1:0] e_ds;
      logic [15:0] e_rd;
      e_br = m_ph >= 1 && m_ph <= 4;
      e_ds = (m_ph != 4) ? 2'b00 : (m_w == 1) ? (m_adr[0] ? 2'b10 : 2'b01) : 2'b11;
      case (m_roff)
        4'h0: e_rd = m_dat[15:0];
        4'h2: e_rd = m_dat[31:16];
        4'h4: e_rd = m_adr[15:0];
        4'h6: e_rd = m_adr[31:16];
        4'h8: e_rd = {9'b0, m_am};
        4'hC: e_rd = {7'b0, m_flag, 2'b0, m_inc, 1'b0, m_offl, 3'b0};
        default: e_rd = 0;
      endcase
      bad = 0;
      sig("R4 request", vme_br, e_br);
      sig("R4 address strobe", vme_as, m_ph == 3 || m_ph == 4);
      sig("R7 data strobes", vme_ds, e_ds);
      sig("R3 wait", hst_wait, m_ph != 0 || (hst_sel && hst_off == 0 && !m_offl));
      sig("R5 write line", vme_write, m_wr && e_br);
      sig("R6 long-word", vme_lword, m_w == 4 && e_br);
      sig("R6 modifier", vme_am, m_am[5:0]);
      sig("R8 address", vme_addr, m_adr);
      sig("R5 data out", vme_dout, m_dat);
      sig("R2 read port", hst_rdata, e_rd);
      sig("R12 system reset", vme_sysreset, m_sysr);
      vectors++;
      if (bad) miscompares++;
      if (vme_br) br_cycles++;
      if (vme_lword) saw_lw = 1;
      if (vme_ds != 0) begin ds_run++; last_ds = vme_ds; end
      else begin if (ds_run > 0) last_run = ds_run; ds_run = 0; end
    end
  end

  task automatic host(input bit wr, input logic [3:0] off, input logic [15:0] d, input bit byt);
    @(posedge clk); #1;
    hst_sel = 1; hst_wr = wr; hst_off = off; hst_wdata = d; hst_byte = byt;
    @(posedge clk); #1;
    hst_sel = 0; hst_wr = 0; hst_byte = 0;
    while (hst_wait) begin @(posedge clk); #1; end
  endtask

  task automatic rd(input logic [3:0] off, input logic [15:0] exp, input string tag);
    host(0, off, 16'h0, 0);
    @(negedge clk);
    check(tag, hst_rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check("R1 request", vme_br, 0);
    check("R1 strobes", {vme_as, vme_ds}, 0);
    check("R1 wait", hst_wait, 0);
    check("R1 read port", hst_rdata, 0);
    check("R1 sysreset", vme_sysreset, 0);
    check("R1 address", vme_addr, 0);

    host(1, 4'h8, 16'h0039, 0);
    host(1, 4'h4, 16'h0000, 0);
    host(1, 4'h6, 16'h001C, 0);
    rd(4'h8, 16'h0039, "R2 modifier");
    rd(4'h6, 16'h001C, "R2 address high");
    rd(4'h4, 16'h0000, "R2 address low");
    rd(4'hA, 16'h0000, "R2 unmapped offset");

    host(1, 4'hC, 16'h0020, 0);
    host(1, 4'h0, 16'h1234, 0);
    check("R7 16-bit lanes", last_ds, 2'b11);
    rd(4'h4, 16'h0002, "R8 step of 2");
    rd(4'hC, 16'h0020, "R2 control readback");

    host(1, 4'h0, 16'h00AB, 1);
    check("R7 even byte lane", last_ds, 2'b01);
    host(1, 4'h0, 16'h00CD, 1);
    check("R7 odd byte lane", last_ds, 2'b10);
    rd(4'h4, 16'h0004, "R8 byte steps");

    host(1, 4'h8, 16'h004D, 0);
    vme_din = 32'hCAFEF00D;
    saw_lw = 0;
    host(0, 4'h0, 16'h0, 0);
    check("R6 long-word seen", saw_lw, 1);
    check("R6 both lanes", last_ds, 2'b11);
    host(1, 4'hC, 16'h0028, 0);
    begin
      int brc;
      brc = br_cycles;
      rd(4'h0, 16'hF00D, "R5 read data low");
      rd(4'h2, 16'hCAFE, "R5 read data high");
      host(1, 4'h0, 16'h5555, 0);
      check("R11 no bus cycle", br_cycles, brc);
      rd(4'h0, 16'h5555, "R11 data stored");
      rd(4'h4, 16'h0008, "R11 address unchanged");
    end

    host(1, 4'h4, 16'h12FE, 0);
    host(1, 4'hC, 16'h0020, 0);
    host(1, 4'h0, 16'h0000, 0);
    rd(4'h4, 16'h1202, "R8 wrap without carry");

    rmode = 1;
    host(1, 4'h0, 16'h0001, 0);
    rd(4'hC, 16'h0120, "R9 flag set on BERR");
    host(1, 4'h8, 16'h004D, 0);
    rd(4'hC, 16'h0020, "R9 flag cleared by modifier write");

    rmode = 2;
    host(1, 4'h0, 16'h0002, 0);
    check("R10 timeout length", last_run, 64);
    rd(4'hC, 16'h0120, "R10 flag set on timeout");

    host(1, 4'h4, 16'h34AB, 0);
    @(posedge clk); #1;
    hst_sel = 1; hst_wr = 1; hst_off = 4'h0; hst_wdata = 16'h0;
    @(posedge clk); #1;
    hst_sel = 0;
    repeat (10) @(posedge clk);
    #1;
    hst_sel = 1; hst_wr = 1; hst_off = 4'hC; hst_wdata = 16'h0080;
    @(posedge clk); #1;
    hst_sel = 0; hst_wr = 0;
    @(negedge clk);
    check("R12 sysreset high", vme_sysreset, 1);
    check("R12 cycle aborted", vme_br, 0);
    @(negedge clk);
    check("R12 sysreset one clock", vme_sysreset, 0);
    rd(4'hC, 16'h0000, "R12 control cleared");
    rd(4'h4, 16'h3400, "R12 low address cleared");
    rd(4'h8, 16'h004D, "R12 modifier kept");

    repeat (3) @(posedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule